// File: doc/BRIEF.md
# Buffered SPI Host Transfer Engine

This block is an SPI host that runs one full-duplex transfer each time software starts it. Software loads up to 320 bytes into a command buffer through a simple single-cycle bus. It then writes one control word that carries the byte count, a clock-speed code, the choice between SPI mode 0 and mode 3, a chip-select index, a chip-enable hold flag and a start bit. The engine shifts the staged bytes out on MOSI, most significant bit first and starting at buffer index 0. Each byte received on MISO is stored in a response buffer at the same index as the byte that was sent with it.

When the last byte has been exchanged, the engine sets a completion event bit. Software clears that bit by writing a 1 to it. The event drives an interrupt line, and a mask bit can block it. The hold flag keeps the selected chip select asserted between transfers, so one device can take part in an exchange that spans several starts. The SPI clock period is the speed code times the system clock period.

Bus map (byte offsets, 11-bit address): the command buffer is at 0x000, the response buffer at 0x200, the control word at 0x400, the event register at 0x420 and the mask register at 0x424. Read data appears one cycle after the read.

Top module: `spi_xfer_host`

## Requirements
- R1: After reset, all chip selects are high, the SPI clock is low, the interrupt is low, the event register reads 0, the mask register reads 0x100 and the control word reads 0.
- R2: MOSI carries command-buffer bytes 0 to N-1 in order, each most significant bit first. The value on MOSI is valid at every rising edge of the SPI clock.
- R3: The byte sampled on MISO at the eight rising clock edges of byte i is written to response-buffer index i, with the first bit as the most significant bit.
- R4: Each bit takes exactly `code` system clocks, where `code` is control bits 7:5. Codes 0 and 1 act as 2. A transfer of N bytes gives exactly 8N rising SPI clock edges and keeps its chip select low for 8N*code cycles.
- R5: Control bit 2 selects the idle level of the SPI clock: 0 means low (mode 0) and 1 means high (mode 3). In both modes, data is sampled on the rising edge.
- R6: At the end of a transfer, event bit 8 becomes 1. Writing 1 to bit 8 at 0x420 clears it, and writing 0 leaves it unchanged.
- R7: The interrupt is high exactly while event bit 8 is 1 and mask bit 8 (0x424) is 0.
- R8: A byte count of 0 (control bits 16:8) sets the event without any SPI clock edge and without asserting a chip select.
- R9: While control bit 4 is 1, the selected chip select stays low between transfers. Writing the bit back to 0 releases it.
- R10: The chip selects are active low. During a transfer, or while the hold flag is set, only line `sel` goes low, where `sel` is control bits 27:25. A value of 7 selects no line.
- R11: A transfer starts when control bit 0 is written as 1 while the engine is idle. Control bit 0 reads 1 while the transfer runs and 0 after it ends. Control writes during a transfer are ignored.
- R12: A byte count above 320 is treated as 320.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 11 | Byte offset |
| bus_wdata | input | 32 | Write data (buffers use bits 7:0) |
| bus_rdata | output | 32 | Read data, one cycle after the read |
| spi_sclk | output | 1 | SPI clock |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |
| spi_cs_n | output | 7 | Active-low chip selects |
| irq | output | 1 | Completion interrupt |

## Verification
The embedded assertions check, on every cycle, that at most one chip select is low and that the divider count stays inside the period set by the speed code. They also check that a completion always sets the event bit, that a zero-length start never makes the engine busy, that the byte index never passes the last byte, and that a control write during a transfer leaves the control word unchanged. Bit order, the reuse of the byte index between buffers, the exact number of clock edges and select cycles per speed code, the idle level in each mode, and the effect of the hold flag across transfers are visible only at the pins. The bench shows them by running scenarios against a device model that answers with a known pattern.

// File: rtl/spi_xfer_pkg.sv
`timescale 1ns/1ps
package spi_xfer_pkg;
  localparam int unsigned XFER_BYTES = 320;
  localparam int unsigned CS_LINES   = 7;
  localparam int unsigned ADDR_W     = 11;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned SEL_W      = 3;
  localparam int unsigned LEN_W      = 9;
  localparam int unsigned CODE_W     = 3;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 11'h400;
  localparam logic [ADDR_W-1:0] OFS_EVT  = 11'h420;
  localparam logic [ADDR_W-1:0] OFS_MASK = 11'h424;

  localparam int unsigned BIT_GO    = 0;
  localparam int unsigned BIT_MODE  = 2;
  localparam int unsigned BIT_HOLD  = 4;
  localparam int unsigned BIT_EVENT = 8;

  typedef struct packed {
    logic [SEL_W-1:0]  sel;
    logic [LEN_W-1:0]  len;
    logic [CODE_W-1:0] code;
    logic              hold;
    logic              mode3;
  } ctrl_t;
endpackage

// File: rtl/spi_xfer_divider.sv
`timescale 1ns/1ps
module spi_xfer_divider #(
  parameter int unsigned CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [CODE_W-1:0] code,
  output logic              phase_hi,
  output logic              smp_stb,
  output logic              end_stb
);
  localparam logic [CODE_W-1:0] ONE = CODE_W'(1);
  localparam logic [CODE_W-1:0] TWO = CODE_W'(2);

  logic [CODE_W-1:0] div, lo, last, cnt_q, cnt_n;

  always_comb begin
    div  = (code < TWO) ? TWO : code;
    lo   = div - (div >> 1);
    last = div - ONE;
    if (!run)               cnt_n = '0;
    else if (cnt_q == last) cnt_n = '0;
    else                    cnt_n = cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign phase_hi = run && (cnt_q >= lo);
  assign smp_stb  = run && (cnt_q == lo - ONE);
  assign end_stb  = run && (cnt_q == last);

  AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= last)); // R4
endmodule

// File: rtl/spi_xfer_engine.sv
`timescale 1ns/1ps
module spi_xfer_engine #(
  parameter int unsigned BUF_BYTES = 320,
  parameter int unsigned LEN_W     = 9,
  localparam int unsigned IDX_W    = $clog2(BUF_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] start_len,
  input  logic             smp_stb,
  input  logic             end_stb,
  input  logic [7:0]       cmd_byte,
  input  logic             miso,
  output logic             busy,
  output logic             done,
  output logic [IDX_W-1:0] idx,
  output logic             rsp_we,
  output logic [7:0]       rsp_data,
  output logic             mosi
);
  logic             busy_q, busy_n, done_q, done_n, we;
  logic [IDX_W-1:0] idx_q, idx_n, last_q, last_n;
  logic [2:0]       bit_q, bit_n;
  logic [7:0]       rx_q, rx_n;

  always_comb begin
    busy_n = busy_q;
    done_n = 1'b0;
    idx_n  = idx_q;
    last_n = last_q;
    bit_n  = bit_q;
    rx_n   = rx_q;
    we     = 1'b0;
    if (!busy_q) begin
      if (start) begin
        if (start_len == '0) begin
          done_n = 1'b1;
        end else begin
          busy_n = 1'b1;
          idx_n  = '0;
          bit_n  = 3'd7;
          last_n = IDX_W'(start_len - LEN_W'(1));
        end
      end
    end else begin
      if (smp_stb) rx_n = {rx_q[6:0], miso};
      if (end_stb) begin
        if (bit_q == 3'd0) begin
          we    = 1'b1;
          bit_n = 3'd7;
          if (idx_q == last_q) begin
            busy_n = 1'b0;
            done_n = 1'b1;
          end else begin
            idx_n = idx_q + IDX_W'(1);
          end
        end else begin
          bit_n = bit_q - 3'd1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
      last_q <= '0;
      bit_q  <= 3'd7;
      rx_q   <= '0;
    end else begin
      busy_q <= busy_n;
      done_q <= done_n;
      idx_q  <= idx_n;
      last_q <= last_n;
      bit_q  <= bit_n;
      rx_q   <= rx_n;
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign idx      = idx_q;
  assign rsp_we   = we;
  assign rsp_data = rx_q;
  assign mosi     = busy_q & cmd_byte[bit_q];

  AST_ZERO_LEN_NO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && start && start_len == '0) |=> (!busy_q && done_q)); // R8
  AST_IDX_WITHIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (idx_q <= last_q)); // R12
endmodule

// File: rtl/spi_xfer_host.sv
`timescale 1ns/1ps
module spi_xfer_host
  import spi_xfer_pkg::*;
#(
  parameter int unsigned BUF_BYTES = XFER_BYTES,
  parameter int unsigned NUM_CS    = CS_LINES,
  localparam int unsigned IDX_W    = $clog2(BUF_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [NUM_CS-1:0] spi_cs_n,
  output logic              irq
);
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic             wr, rd, in_cmd, in_rsp, ctrl_wr, start, busy, done;
  logic             evt_q, evt_n, mask_q, mask_n, rsp_we, phase_hi, smp_stb, end_stb;
  logic [IDX_W-1:0] buf_ix, idx;
  logic [7:0]       rsp_data, cmd_byte;
  logic [LEN_W-1:0] wr_len, start_len;
  ctrl_t            ctrl_q, ctrl_n;
  logic [DATA_W-1:0] rd_mux, rdata_q;

  logic [7:0] cmd_mem [BUF_BYTES];
  logic [7:0] rsp_mem [BUF_BYTES];

  assign wr      = bus_sel & bus_we;
  assign rd      = bus_sel & ~bus_we;
  assign buf_ix  = bus_addr[IDX_W-1:0];
  assign in_cmd  = (bus_addr[ADDR_W-1:9] == 2'd0) && (32'(buf_ix) < BUF_BYTES);
  assign in_rsp  = (bus_addr[ADDR_W-1:9] == 2'd1) && (32'(buf_ix) < BUF_BYTES);
  assign ctrl_wr = wr && (bus_addr == OFS_CTRL) && !busy;
  assign start   = ctrl_wr && bus_wdata[BIT_GO];
  assign wr_len  = bus_wdata[16:8];
  assign start_len = (32'(wr_len) > BUF_BYTES) ? LEN_W'(BUF_BYTES) : wr_len;

  always_ff @(posedge clk) begin
    if (wr && in_cmd) cmd_mem[buf_ix] <= bus_wdata[7:0];
    if (rsp_we)       rsp_mem[idx]    <= rsp_data;
  end
  assign cmd_byte = cmd_mem[idx];

  always_comb begin
    ctrl_n = ctrl_q;
    if (ctrl_wr) begin
      ctrl_n.sel   = bus_wdata[27:25];
      ctrl_n.len   = wr_len;
      ctrl_n.code  = bus_wdata[7:5];
      ctrl_n.hold  = bus_wdata[BIT_HOLD];
      ctrl_n.mode3 = bus_wdata[BIT_MODE];
    end
    evt_n  = (evt_q & ~(wr && bus_addr == OFS_EVT && bus_wdata[BIT_EVENT])) | done;
    mask_n = (wr && bus_addr == OFS_MASK) ? bus_wdata[BIT_EVENT] : mask_q;
    rd_mux = '0;
    if (in_cmd)                    rd_mux[7:0] = cmd_mem[buf_ix];
    else if (in_rsp)               rd_mux[7:0] = rsp_mem[buf_ix];
    else if (bus_addr == OFS_CTRL) rd_mux = {4'd0, ctrl_q.sel, 8'd0, ctrl_q.len, ctrl_q.code,
                                             ctrl_q.hold, 1'b0, ctrl_q.mode3, 1'b0, busy};
    else if (bus_addr == OFS_EVT)  rd_mux[BIT_EVENT] = evt_q;
    else if (bus_addr == OFS_MASK) rd_mux[BIT_EVENT] = mask_q;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      ctrl_q  <= '0;
      evt_q   <= 1'b0;
      mask_q  <= 1'b1;
      rdata_q <= '0;
    end else begin
      ctrl_q <= ctrl_n;
      evt_q  <= evt_n;
      mask_q <= mask_n;
      if (rd) rdata_q <= rd_mux;
    end
  end

  spi_xfer_divider #(.CODE_W(CODE_W)) u_div (
    .clk(clk), .rst_n(rst_core_n), .run(busy), .code(ctrl_q.code),
    .phase_hi(phase_hi), .smp_stb(smp_stb), .end_stb(end_stb)
  );

  spi_xfer_engine #(.BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W)) u_eng (
    .clk(clk), .rst_n(rst_core_n), .start(start), .start_len(start_len),
    .smp_stb(smp_stb), .end_stb(end_stb), .cmd_byte(cmd_byte), .miso(spi_miso),
    .busy(busy), .done(done), .idx(idx), .rsp_we(rsp_we), .rsp_data(rsp_data),
    .mosi(spi_mosi)
  );

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign spi_cs_n[g] = ~((busy | ctrl_q.hold) && (ctrl_q.sel == SEL_W'(g)));
  end

  assign spi_sclk  = busy ? phase_hi : ctrl_q.mode3;
  assign irq       = evt_q & ~mask_q;
  assign bus_rdata = rdata_q;

  AST_ONE_CS_LOW: assert property (@(posedge clk) disable iff (!rst_core_n)
    $onehot0(~spi_cs_n)); // R10
  AST_CTRL_FROZEN: assert property (@(posedge clk) disable iff (!rst_core_n)
    (busy && wr && bus_addr == OFS_CTRL) |=> $stable(ctrl_q)); // R11
  AST_DONE_SETS_EVENT: assert property (@(posedge clk) disable iff (!rst_core_n)
    done |=> evt_q); // R6
endmodule

// File: tb/test_spi_xfer_host.sv
`timescale 1ns/1ps
module test_spi_xfer_host;
  logic        clk, rst_n, bus_sel, bus_we, spi_sclk, spi_mosi, spi_miso, irq;
  logic [10:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [6:0]  spi_cs_n;

  int errors = 0;
  int checks = 0;

  spi_xfer_host i_spi_xfer_host (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [7:0] cmd_pat(int i, int seed);
    return 8'((i * 29) + (seed * 7) + 5);
  endfunction
  function automatic logic [7:0] rsp_pat(int i);
    return 8'(i * 13) ^ 8'hC3;
  endfunction

  // device model: answers byte i with rsp_pat(i), captures MOSI bytes
  int         rcnt = 0;
  int         rbase = 0;
  logic [7:0] sh = '0;
  logic [7:0] mosi_cap [320];
  always @(posedge spi_sclk) begin
    if (spi_cs_n != 7'h7F) begin
      sh = {sh[6:0], spi_mosi};
      if (((rcnt - rbase) % 8) == 7 && (rcnt - rbase) / 8 < 320) mosi_cap[(rcnt - rbase) / 8] = sh;
      rcnt = rcnt + 1;
    end
  end
  always_comb begin
    logic [7:0] b;
    b = rsp_pat((rcnt - rbase) / 8);
    spi_miso = b[7 - ((rcnt - rbase) % 8)];
  end

  logic       mon_clr = 1'b0;
  int         cs_cyc = 0;
  logic [6:0] seen = '0;
  always @(negedge clk) begin
    if (mon_clr) begin
      cs_cyc = 0;
      seen = '0;
    end else begin
      if (spi_cs_n != 7'h7F) cs_cyc = cs_cyc + 1;
      seen = seen | ~spi_cs_n;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [10:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [10:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] ctrl_word(int len, int code, int mode, int sel, int hold, int go);
    return (32'(sel) << 25) | (32'(len) << 8) | (32'(code) << 5) | (32'(hold) << 4) |
           (32'(mode) << 2) | 32'(go);
  endfunction

  task automatic wait_evt(output bit got);
    logic [31:0] d;
    got = 1'b0;
    for (int k = 0; k < 20000 && !got; k++) begin
      bus_read(11'h420, d);
      got = d[8];
    end
  endtask

  task automatic prep(input int len, input int seed);
    int n;
    n = (len > 320) ? 320 : len;
    for (int i = 0; i < n; i++) bus_write(11'(i), {24'd0, cmd_pat(i, seed)});
    @(negedge clk); mon_clr = 1'b1; rbase = rcnt;
    @(negedge clk); mon_clr = 1'b0;
  endtask

  // vector fields: len[15:7], code[6:4], mode[3], sel[2:0]
  localparam logic [15:0] VEC [6] = '{
    {9'd1, 3'd2, 1'b0, 3'd0}, {9'd3, 3'd3, 1'b1, 3'd1}, {9'd5, 3'd4, 1'b0, 3'd3},
    {9'd2, 3'd5, 1'b1, 3'd4}, {9'd4, 3'd7, 1'b0, 3'd6}, {9'd2, 3'd0, 1'b1, 3'd5}
  };

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    bit got;
    int len, code, mode, sel, dv, n;
    bus_sel = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0;
    rst_n = 1'b0;
    #55 rst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk(spi_cs_n == 7'h7F, "R1 cs_n", spi_cs_n, 7'h7F);
    chk(spi_sclk == 1'b0, "R1 sclk", spi_sclk, 0);
    chk(irq == 1'b0, "R1 irq", irq, 0);
    bus_read(11'h420, d); chk(d == 0, "R1 event", d, 0);
    bus_read(11'h424, d); chk(d == 32'h100, "R1 mask", d, 32'h100);
    bus_read(11'h400, d); chk(d == 0, "R1 ctrl", d, 0);
    bus_write(11'h424, 32'h0);

    foreach (VEC[v]) begin
      len = int'(VEC[v][15:7]); code = int'(VEC[v][6:4]);
      mode = int'(VEC[v][3]); sel = int'(VEC[v][2:0]);
      dv = (code < 2) ? 2 : code;
      prep(len, v);
      bus_write(11'h400, ctrl_word(len, code, mode, sel, 0, 1));
      wait_evt(got);
      chk(got, "R6 event set", got, 1);
      chk(irq == 1'b1, "R7 irq unmasked", irq, 1);
      for (int i = 0; i < len; i++)
        chk(mosi_cap[i] == cmd_pat(i, v), "R2 mosi byte", mosi_cap[i], cmd_pat(i, v));
      for (int i = 0; i < len; i++) begin
        bus_read(11'h200 + 11'(i), d);
        chk(d[7:0] == rsp_pat(i), "R3 response byte", d[7:0], rsp_pat(i));
      end
      chk(rcnt - rbase == len * 8, "R4 rising edges", rcnt - rbase, len * 8);
      chk(cs_cyc == len * 8 * dv, "R4 select cycles", cs_cyc, len * 8 * dv);
      chk(seen == 7'(1 << sel), "R10 select line", seen, 1 << sel);
      chk(spi_sclk == 1'(mode), "R5 idle level", spi_sclk, mode);
      bus_write(11'h420, 32'h0);
      bus_read(11'h420, d); chk(d[8] == 1'b1, "R6 write 0 keeps", d[8], 1);
      bus_write(11'h420, 32'h100);
      bus_read(11'h420, d); chk(d[8] == 1'b0, "R6 w1c clear", d[8], 0);
      chk(irq == 1'b0, "R7 irq follows event", irq, 0);
    end

    // R7 masked, R8 zero length
    bus_write(11'h424, 32'h100);
    prep(0, 0);
    bus_write(11'h400, ctrl_word(0, 3, 0, 2, 0, 1));
    wait_evt(got);
    chk(got, "R8 zero length event", got, 1);
    chk(irq == 1'b0, "R7 masked irq", irq, 0);
    chk(rcnt - rbase == 0, "R8 no clock edges", rcnt - rbase, 0);
    chk(cs_cyc == 0, "R8 no select", cs_cyc, 0);
    bus_write(11'h420, 32'h100);
    bus_write(11'h424, 32'h0);

    // R9 hold across transfers
    prep(2, 9);
    bus_write(11'h400, ctrl_word(2, 2, 0, 2, 1, 1));
    wait_evt(got); bus_write(11'h420, 32'h100);
    chk(spi_cs_n == 7'h7B, "R9 held after first", spi_cs_n, 7'h7B);
    bus_write(11'h400, ctrl_word(2, 2, 0, 2, 1, 1));
    wait_evt(got); bus_write(11'h420, 32'h100);
    chk(spi_cs_n == 7'h7B, "R9 held after second", spi_cs_n, 7'h7B);
    bus_write(11'h400, ctrl_word(2, 2, 0, 2, 0, 0));
    @(negedge clk);
    chk(spi_cs_n == 7'h7F, "R9 released", spi_cs_n, 7'h7F);

    // R10 index 7 selects nothing
    prep(2, 3);
    bus_write(11'h400, ctrl_word(2, 2, 0, 7, 0, 1));
    wait_evt(got);
    chk(got && seen == 7'h00, "R10 index 7 none", seen, 0);
    bus_write(11'h420, 32'h100);

    // R11 writes during a transfer ignored
    prep(4, 4);
    bus_write(11'h400, ctrl_word(4, 4, 0, 1, 0, 1));
    repeat (20) @(negedge clk);
    bus_write(11'h400, ctrl_word(1, 2, 1, 3, 0, 1));
    bus_read(11'h400, d);
    chk(d[0] == 1'b1, "R11 go reads busy", d[0], 1);
    chk(d[16:8] == 9'd4, "R11 len kept", d[16:8], 4);
    wait_evt(got);
    chk(rcnt - rbase == 32, "R11 original length ran", rcnt - rbase, 32);
    bus_read(11'h400, d);
    chk(d[0] == 1'b0, "R11 go clears", d[0], 0);
    bus_write(11'h420, 32'h100);

    // R12 count above buffer size clamps
    prep(330, 5);
    bus_write(11'h400, ctrl_word(330, 2, 0, 0, 0, 1));
    wait_evt(got);
    n = 320;
    chk(rcnt - rbase == n * 8, "R12 clamped edges", rcnt - rbase, n * 8);
    chk(cs_cyc == n * 16, "R12 clamped cycles", cs_cyc, n * 16);
    chk(mosi_cap[319] == cmd_pat(319, 5), "R12 last mosi", mosi_cap[319], cmd_pat(319, 5));
    bus_read(11'h200 + 11'd319, d);
    chk(d[7:0] == rsp_pat(319), "R12 last response", d[7:0], rsp_pat(319));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule